// File: doc/BRIEF.md
# Embedded Timecode Tagger

The tagger watches one timecode bit that rides along a raw sampled data stream. Every sample-valid strobe moves that bit into a sync window. When the window equals a fixed 11-bit Barker sync pattern, the block captures the 32 payload bits that follow. The finished timecode is stored together with the running sample number of the strobe that completed the sync word.

The two newest records are kept as a ping-pong pair with a "newest" flag. A new record always goes into the slot that is not flagged and only then becomes the newest, so a host polling the block never finds a half-written record. A separate latch captures the sample number on each synchronized rising edge of a pulse-per-second input, which gives a finer time reference than the serial code alone. The host reads the records, the status and the pulse latch through a small registered address/data port.

Framing runs on a three-state machine:
- **HUNT** goes to **CAPTURE** on a sync match.
- **CAPTURE** stays in CAPTURE on a new sync match, which restarts the capture.
- **CAPTURE** goes to **COMMIT** when the last payload bit is taken.
- **COMMIT** lasts one cycle and writes the record. It then goes to CAPTURE if a sync match arrives in that cycle, and to HUNT otherwise.

Top module: `tc_tagger`

## Requirements
- R1: After reset, addresses 0 to 3 and 5 read zero and the status word (address 4) reads 1: newest flag set, no slot valid.
- R2: A sync match occurs on a strobe when that strobe and the SYNC_LEN-1 strobes before it equal SYNC_PAT. The earliest of these bits is compared with the pattern MSB. The default pattern is 11'b11100010010. No match is possible before SYNC_LEN strobes have been seen.
- R3: The PAY_W strobed bits that follow a match form the payload. The first of them lands in the payload MSB. A record is committed one clock after the last payload strobe, and two commits are never in adjacent cycles.
- R4: The tag of a record is the sample index of the strobe that completed the sync match. Indexes count strobes since reset, starting at 0, modulo 2^CNT_W.
- R5: A completed record is written into the slot not flagged newest, and the newest flag then points at that slot. The other slot keeps the previous record. The first record after reset goes to slot 0.
- R6: A sync match during capture discards the partial payload. Capture restarts, and the record takes the new match's tag.
- R7: Cycles without a sample-valid strobe change nothing: tc_bit is ignored and the sample counter holds.
- R8: A rising edge of pps_in, after a two-flop synchronizer, latches the current sample count into the pulse register (address 5). A level held high does not latch again.
- R9: Read map: 0 = slot 0 tag, 1 = slot 0 payload, 2 = slot 1 tag, 3 = slot 1 payload, 4 = status, 5 = pulse count, 6 and 7 = zero. Status bit 0 is the newest slot, bit 1 is slot 0 valid and bit 2 is slot 1 valid. Narrow fields are zero-extended. rd_data shows the value for rd_addr one clock after it is sampled.
- R10: The sample counter wraps silently from 2^CNT_W-1 to 0, and tags taken after the wrap carry the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample-valid strobe |
| tc_bit | input | 1 | Timecode bit of the current sample |
| pps_in | input | 1 | Pulse-per-second input, asynchronous |
| rd_addr | input | 3 | Host read address |
| rd_data | output | DATA_W | Registered host read data |

## Verification
The assertions check, on every cycle, the rules that hold at any moment:
- the sample counter advances by exactly one per strobe and holds otherwise;
- the newest flag moves only right after a commit;
- commits never land in adjacent cycles;
- the pulse register changes only three clocks after a low-to-high step of pps_in;
- unmapped addresses read zero.

Only the bench's scenarios can show the end-to-end results: the right payload and tag reaching the right slot, a restart discarding a partial frame, strobe-free junk being ignored, tags wrapping with the small counter, and a held pulse not re-latching.

// File: rtl/tct_pkg.sv
package tct_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_COMMIT  = 2'd2
    } frm_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RA_TAG0 = 3'd0;
    localparam logic [ADDR_W-1:0] RA_PAY0 = 3'd1;
    localparam logic [ADDR_W-1:0] RA_TAG1 = 3'd2;
    localparam logic [ADDR_W-1:0] RA_PAY1 = 3'd3;
    localparam logic [ADDR_W-1:0] RA_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] RA_PPS  = 3'd5;

endpackage

// File: rtl/tct_sync_det.sv
module tct_sync_det #(
    parameter int                  SYNC_LEN = 11,
    parameter logic [SYNC_LEN-1:0] SYNC_PAT = 11'b11100010010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic bit_i,
    output logic hit_o
);

    localparam int FILL_W = $clog2(SYNC_LEN + 1);

    logic [SYNC_LEN-1:0] win_q;
    logic [SYNC_LEN-1:0] win_nx;
    logic [FILL_W-1:0]   fill_q;
    logic                full;

    assign win_nx = {win_q[SYNC_LEN-2:0], bit_i};
    assign full   = (fill_q >= FILL_W'(SYNC_LEN - 1));
    assign hit_o  = vld_i && full && (win_nx == SYNC_PAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (vld_i) begin
            win_q <= win_nx;
            if (!full) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tct_frame_fsm.sv
module tct_frame_fsm
    import tct_pkg::*;
#(
    parameter int PAY_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             bit_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             commit_o,
    output logic [CNT_W-1:0] tag_o,
    output logic [PAY_W-1:0] pay_o
);

    localparam int BC_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;

    frm_state_t       st_q;
    frm_state_t       st_nx;
    logic [BC_W-1:0]  bit_q;
    logic [PAY_W-1:0] pay_q;
    logic [CNT_W-1:0] tag_q;
    logic             last_bit;

    assign last_bit = (bit_q == BC_W'(PAY_W - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HUNT;
        end else begin
            st_q <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_HUNT: begin
                if (hit_i) st_nx = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (hit_i)                  st_nx = ST_CAPTURE;
                else if (vld_i && last_bit) st_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                st_nx = hit_i ? ST_CAPTURE : ST_HUNT;
            end
            default: st_nx = ST_HUNT;
        endcase
    end

    // capture datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            pay_q <= '0;
            tag_q <= '0;
        end else if (hit_i) begin
            tag_q <= cnt_i;
            bit_q <= '0;
        end else if ((st_q == ST_CAPTURE) && vld_i) begin
            pay_q <= {pay_q[PAY_W-2:0], bit_i};
            bit_q <= bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        commit_o = (st_q == ST_COMMIT);
        tag_o    = tag_q;
        pay_o    = pay_q;
    end

endmodule

// File: rtl/tct_rec_store.sv
module tct_rec_store #(
    parameter int TAG_W = 32,
    parameter int PAY_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic [PAY_W-1:0]      pay_i,
    output logic [1:0][TAG_W-1:0] tag_o,
    output logic [1:0][PAY_W-1:0] pay_o,
    output logic [1:0]            vld_o,
    output logic                  newest_o
);

    localparam int SLOTS = 2;

    logic newest_q;
    logic wr_sel;

    assign wr_sel   = ~newest_q;
    assign newest_o = newest_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest_q <= 1'b1;
        end else if (wr_i) begin
            newest_q <= wr_sel;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_o[g] <= '0;
                pay_o[g] <= '0;
                vld_o[g] <= 1'b0;
            end else if (wr_i && (wr_sel == 1'(g))) begin
                tag_o[g] <= tag_i;
                pay_o[g] <= pay_i;
                vld_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tct_pps_latch.sv
module tct_pps_latch #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] pps_cnt_o
);

    logic s1_q;
    logic s2_q;
    logic s3_q;
    logic rise;

    assign rise = s2_q & ~s3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q      <= 1'b0;
            s2_q      <= 1'b0;
            s3_q      <= 1'b0;
            pps_cnt_o <= '0;
        end else begin
            s1_q <= pps_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (rise) begin
                pps_cnt_o <= cnt_i;
            end
        end
    end

endmodule

// File: rtl/tc_tagger.sv
module tc_tagger
    import tct_pkg::*;
#(
    parameter int                  DATA_W   = 32,
    parameter int                  CNT_W    = 32,
    parameter int                  PAY_W    = 32,
    parameter int                  SYNC_LEN = 11,
    parameter logic [SYNC_LEN-1:0] SYNC_PAT = 11'b11100010010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              tc_bit,
    input  logic              pps_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [CNT_W-1:0]      smp_cnt_q;
    logic                  hit;
    logic                  rec_wr;
    logic [CNT_W-1:0]      rec_tag;
    logic [PAY_W-1:0]      rec_pay;
    logic [1:0][CNT_W-1:0] tag_s;
    logic [1:0][PAY_W-1:0] pay_s;
    logic [1:0]            vld_s;
    logic                  newest;
    logic [CNT_W-1:0]      pps_cnt;
    logic [DATA_W-1:0]     rd_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_cnt_q <= '0;
        end else if (smp_vld) begin
            smp_cnt_q <= smp_cnt_q + 1'b1;
        end
    end

    tct_sync_det #(
        .SYNC_LEN(SYNC_LEN),
        .SYNC_PAT(SYNC_PAT)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(smp_vld),
        .bit_i(tc_bit),
        .hit_o(hit)
    );

    tct_frame_fsm #(
        .PAY_W(PAY_W),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (smp_vld),
        .bit_i   (tc_bit),
        .hit_i   (hit),
        .cnt_i   (smp_cnt_q),
        .commit_o(rec_wr),
        .tag_o   (rec_tag),
        .pay_o   (rec_pay)
    );

    tct_rec_store #(
        .TAG_W(CNT_W),
        .PAY_W(PAY_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (rec_wr),
        .tag_i   (rec_tag),
        .pay_i   (rec_pay),
        .tag_o   (tag_s),
        .pay_o   (pay_s),
        .vld_o   (vld_s),
        .newest_o(newest)
    );

    tct_pps_latch #(
        .CNT_W(CNT_W)
    ) u_pps (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_i    (pps_in),
        .cnt_i    (smp_cnt_q),
        .pps_cnt_o(pps_cnt)
    );

    always_comb begin
        rd_nx = '0;
        case (rd_addr)
            RA_TAG0: rd_nx = DATA_W'(tag_s[0]);
            RA_PAY0: rd_nx = DATA_W'(pay_s[0]);
            RA_TAG1: rd_nx = DATA_W'(tag_s[1]);
            RA_PAY1: rd_nx = DATA_W'(pay_s[1]);
            RA_STAT: rd_nx = DATA_W'({vld_s[1], vld_s[0], newest});
            RA_PPS:  rd_nx = DATA_W'(pps_cnt);
            default: rd_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_nx;
        end
    end

endmodule

// File: rtl/tct_chk.sv
module tct_chk
    import tct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic              pps_in,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  cnt,
    input logic              rec_wr,
    input logic              newest,
    input logic [CNT_W-1:0]  pps_cnt
);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(cnt));

    // R5
    newest_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(newest) |-> $past(rec_wr));

    // R3
    commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_wr |=> !rec_wr);

    // R8
    pps_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pps_cnt) |-> ($past(pps_in, 3) && !$past(pps_in, 4)));

    // R9
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > RA_PPS) |=> rd_data == '0);

endmodule

bind tc_tagger tct_chk #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_vld(smp_vld),
    .pps_in (pps_in),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .cnt    (smp_cnt_q),
    .rec_wr (rec_wr),
    .newest (newest),
    .pps_cnt(pps_cnt)
);

// File: tb/tb_tc_tagger.sv
module tb_tc_tagger;

    localparam int          DW = 32;
    localparam int          CW = 8;
    localparam int          PW = 32;
    localparam int          SL = 11;
    localparam logic [10:0] SP = 11'b11100010010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        tc_bit = 1'b0;
    logic        pps_in = 1'b0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;

    always #10 clk = ~clk;

    tc_tagger #(
        .DATA_W(DW), .CNT_W(CW), .PAY_W(PW), .SYNC_LEN(SL), .SYNC_PAT(SP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .tc_bit(tc_bit),
        .pps_in(pps_in), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          scnt = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    logic        e_new = 1'b1;
    logic [31:0] e_tag [2];
    logic [31:0] e_pay [2];
    logic        e_v [2];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(logic b);
        @(negedge clk);
        smp_vld = 1'b1;
        tc_bit  = b;
        scnt++;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            smp_vld = 1'b0;
            tc_bit  = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        smp_vld = 1'b0;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    function automatic bit clean(logic [31:0] p, int tail);
        logic        st [64];
        int          n = 0;
        logic [10:0] w;
        for (int i = SL - 1; i >= 0; i--) begin st[n] = SP[i]; n++; end
        for (int i = 31; i >= 0; i--) begin st[n] = p[i]; n++; end
        for (int i = 0; i < tail; i++) begin st[n] = 1'b0; n++; end
        for (int e = SL; e < n; e++) begin
            w = '0;
            for (int k = e - SL + 1; k <= e; k++) w = {w[9:0], st[k]};
            if (w == SP) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic gen_pay(int tail, output logic [31:0] p);
        do begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            p = lfsr;
        end while (!clean(p, tail));
    endtask

    task automatic send_sync(bit gaps, output logic [31:0] tag);
        for (int i = SL - 1; i >= 0; i--) begin
            strobe(SP[i]);
            if (gaps) idle(1 + (i % 3));
        end
        tag = 32'((scnt - 1) % 256);
    endtask

    task automatic send_pay(logic [31:0] p, bit gaps);
        for (int i = 31; i >= 0; i--) begin
            strobe(p[i]);
            if (gaps && (i % 4 == 0)) idle(2);
        end
    endtask

    task automatic zeros(int n);
        repeat (n) strobe(1'b0);
    endtask

    task automatic record(logic [31:0] tag, logic [31:0] pay);
        int s;
        s = e_new ? 0 : 1;
        e_tag[s] = tag;
        e_pay[s] = pay;
        e_v[s]   = 1'b1;
        e_new    = 1'(s);
    endtask

    task automatic verify(string req);
        logic [31:0] v;
        rd(3'd4, v); chk({req, " status"}, v, {29'b0, e_v[1], e_v[0], e_new});
        rd(3'd0, v); chk({req, " slot0 tag"}, v, e_tag[0]);
        rd(3'd1, v); chk({req, " slot0 payload"}, v, e_pay[0]);
        rd(3'd2, v); chk({req, " slot1 tag"}, v, e_tag[1]);
        rd(3'd3, v); chk({req, " slot1 payload"}, v, e_pay[1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, tg, tg2, pa, pb;
        e_tag[0] = '0; e_tag[1] = '0; e_pay[0] = '0; e_pay[1] = '0;
        e_v[0] = 1'b0; e_v[1] = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        verify("R1");
        rd(3'd5, v); chk("R1 pulse count", v, 32'd0);

        // R2 R3 R4 R5 R7: frame sweep, junk while strobe low on odd frames
        for (int f = 0; f < 12; f++) begin
            gen_pay(10, pa);
            send_sync(f[0], tg);
            send_pay(pa, f[0]);
            zeros(10);
            idle(2);
            record(tg, pa);
            if (scnt > 256) verify("R10 R4 wrapped tag");
            else verify("R2 R3 R4 R5 R7 frame");
        end

        // R6 restart: partial frame discarded by new sync
        send_sync(1'b0, tg);
        zeros(10);
        gen_pay(10, pa);
        send_sync(1'b0, tg2);
        send_pay(pa, 1'b0);
        zeros(10);
        idle(2);
        record(tg2, pa);
        verify("R6 restart");

        // R5 back-to-back frames
        gen_pay(0, pa);
        gen_pay(10, pb);
        send_sync(1'b0, tg);
        send_pay(pa, 1'b0);
        send_sync(1'b0, tg2);
        send_pay(pb, 1'b0);
        zeros(10);
        idle(2);
        record(tg, pa);
        record(tg2, pb);
        verify("R5 back-to-back");

        // R8 pulse latch
        @(negedge clk); smp_vld = 1'b0; pps_in = 1'b1;
        idle(6);
        tg = 32'(scnt % 256);
        rd(3'd5, v); chk("R8 pulse latch", v, tg);
        zeros(20);
        idle(4);
        rd(3'd5, v); chk("R8 held level no relatch", v, tg);
        @(negedge clk); pps_in = 1'b0;
        zeros(7);
        @(negedge clk); smp_vld = 1'b0; pps_in = 1'b1;
        idle(6);
        rd(3'd5, v); chk("R8 second edge", v, 32'(scnt % 256));
        pps_in = 1'b0;

        // R9 unmapped addresses
        rd(3'd6, v); chk("R9 addr6", v, 32'd0);
        rd(3'd7, v); chk("R9 addr7", v, 32'd0);
        verify("R9 map after pulse test");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule